// File: doc/BRIEF.md
# Rotating-Offset Masked Substitution Layer

This block performs the byte substitution step of a masked AES-style cipher on a 16-byte state, one round per clock. Each byte lane looks up a composite table made of sixteen masked S-boxes. Masked table i takes a byte carrying mask m_i and returns the substituted byte carrying mask m_(i+1), with indices taken modulo 16. The masks come from a small public set, so no mask path runs beside the data path. What stays secret is the 4-bit starting offset, which the surrounding logic loads at the start of every encryption.

The table address is 12 bits wide: the 4-bit table index sits in the upper bits and the masked byte in the lower bits. That address is registered at the table input, and this register is the round state. Lane j uses index offset + j + round, so neighbouring lanes sit one table apart. Each round every byte moves one table further on. Two lanes share each dual-port table instance.

After the lookup, a correction constant is XORed into every lane. It re-masks each byte so that, after the row-rotation byte permutation that follows this layer, the byte carries the mask its new lane expects in the next round. The column mixing, the key schedule and the random source sit outside the block.

Top module: `masked_sbox_layer`

## Requirements
- R1: The mask set, in index order 0 to 15, is 245, 226, 222, 201, 187, 172, 144, 135, 120, 111, 83, 68, 54, 33, 29, 10. A lane using table index i maps input x XOR m_i to S(x) XOR m_(i+1), where S is the AES S-box; for example, offset 0, round 0, lane 0 with true byte 0x53 gives 0xED XOR 0xE2 = 0x0F before correction.
- R2: Lane j (stateIn bits 8j+7..8j) in round r (counted from 0 after start) uses table index (offset + j + r) mod 16, so it expects its input byte masked with m_((offset+j+r) mod 16).
- R3: After round r, output lane s carries S(x_s) XOR m_((offset + d(s) + r + 1) mod 16). Here x_s is the unmasked input byte of lane s, and d(s) = 4*((c - w) mod 4) + w with w = s mod 4 and c = s div 4 (the lane the byte moves to under row rotation).
- R4: A round strobe is accepted on every clock while busy, and its result appears on stateOut in the cycle that follows the capturing edge, so back-to-back strobes give one round per clock.
- R5: done rises in the cycle after the tenth accepted strobe, and the block returns to idle at that point. A start accepted in idle clears done.
- R6: A start while busy is ignored: the offset and the round count in use do not change.
- R7: A round strobe while idle is ignored: stateOut and done hold.
- R8: After reset, done is 0, the offset is 0 and lane j's registered address holds index j with byte 0. Each lane s therefore shows S(m_s) XOR m_((d(s)+1) mod 16).
- R9: Index arithmetic wraps modulo 16, so an offset of 15 gives the same mask rules as any other offset.
- R10: While busy, cycles without a strobe leave stateOut and the round count unchanged, whatever stateIn does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encryption and load the offset (idle only) |
| offsetIn | input | 4 | Secret starting table offset |
| roundStrobe | input | 1 | Capture stateIn as the next round's table addresses |
| stateIn | input | 128 | Masked state, lane j at bits 8j+7..8j |
| stateOut | output | 128 | Substituted, re-masked and corrected state |
| done | output | 1 | High after the tenth round until the next start |

## Verification
The bench builds the block with its default values: sixteen lanes, ten rounds and a 4-bit table index. With these, every offset class, including the wrap at offset 15, shows up within one encryption, and the layout of all eight shared table instances is fixed. The expected outputs come from the bench's own S-box, built from exponent and logarithm tables over the field. They are compared per round against the row-rotation mask rule, under back-to-back strobes, pauses in the middle of an encryption, and start or strobe pulses that must be ignored.

// File: rtl/masked_sbox_layer_pkg.sv
package masked_sbox_layer_pkg;

  localparam int LANES    = 16;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int ADDR_W   = IDX_W + BYTE_W;
  localparam int STATE_W  = LANES * BYTE_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] baseIdx;
  } ctrl_t;

  // Public mask set, index order matters
  function automatic logic [BYTE_W-1:0] maskAt(input logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] m;
    case (idx)
      4'd0:  m = 8'd245;
      4'd1:  m = 8'd226;
      4'd2:  m = 8'd222;
      4'd3:  m = 8'd201;
      4'd4:  m = 8'd187;
      4'd5:  m = 8'd172;
      4'd6:  m = 8'd144;
      4'd7:  m = 8'd135;
      4'd8:  m = 8'd120;
      4'd9:  m = 8'd111;
      4'd10: m = 8'd83;
      4'd11: m = 8'd68;
      4'd12: m = 8'd54;
      4'd13: m = 8'd33;
      4'd14: m = 8'd29;
      default: m = 8'd10;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
    end
    return acc;
  endfunction

  // Field inverse by x^254 followed by the affine map
  function automatic logic [7:0] aesSbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] y;
    inv = 8'h01;
    for (int i = 0; i < 254; i++) inv = gfMul(inv, x);
    y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return y;
  endfunction

  // Lane a byte moves to under the downstream row rotation
  function automatic int laneDest(input int s);
    int row;
    int col;
    row = s % 4;
    col = s / 4;
    return 4 * ((col - row + 4) % 4) + row;
  endfunction

endpackage

// File: rtl/msl_table.sv
module msl_table
  import masked_sbox_layer_pkg::*;
#(
  parameter int BASE_LANE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [ADDR_W-1:0] addrInA,
  input  logic [ADDR_W-1:0] addrInB,
  output logic [ADDR_W-1:0] addrQA,
  output logic [ADDR_W-1:0] addrQB,
  output logic [BYTE_W-1:0] dataA,
  output logic [BYTE_W-1:0] dataB
);

  localparam int PORTS     = 2;
  localparam int ROM_DEPTH = 1 << BYTE_W;

  logic [BYTE_W-1:0] sboxRom [ROM_DEPTH];
  logic [ADDR_W-1:0] addrIn  [PORTS];
  logic [ADDR_W-1:0] addrQ   [PORTS];
  logic [BYTE_W-1:0] dataOut [PORTS];

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_rom
    assign sboxRom[k] = aesSbox(BYTE_W'(k));
  end

  assign addrIn[0] = addrInA;
  assign addrIn[1] = addrInB;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam logic [IDX_W-1:0] RST_IDX = IDX_W'(BASE_LANE + p);
    logic [IDX_W-1:0]  tblIdx;
    logic [BYTE_W-1:0] rawByte;

    // Registered address doubles as the state register
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)   addrQ[p] <= {RST_IDX, {BYTE_W{1'b0}}};
      else if (en) addrQ[p] <= addrIn[p];
    end

    assign tblIdx  = addrQ[p][ADDR_W-1:BYTE_W];
    assign rawByte = addrQ[p][BYTE_W-1:0];
    // Composite entry: strip m_i, substitute, apply m_(i+1)
    assign dataOut[p] = sboxRom[rawByte ^ maskAt(tblIdx)] ^ maskAt(tblIdx + 4'd1);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      !en |=> $stable(addrQ[p]));
  end

  assign addrQA = addrQ[0];
  assign addrQB = addrQ[1];
  assign dataA  = dataOut[0];
  assign dataB  = dataOut[1];

endmodule

// File: rtl/msl_ctrl.sv
module msl_ctrl
  import masked_sbox_layer_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] offsetIn,
  input  logic             roundStrobe,
  output ctrl_t            ctrl,
  output logic             done
);

  localparam int CNT_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

  logic             busy;
  logic [IDX_W-1:0] offsetReg;
  logic [CNT_W-1:0] roundCnt;
  logic             accept;

  assign accept = busy && roundStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      offsetReg <= '0;
      roundCnt  <= '0;
    end else if (!busy && start) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      offsetReg <= offsetIn;
      roundCnt  <= '0;
    end else if (accept) begin
      if (roundCnt == LAST) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        roundCnt <= '0;
      end else begin
        roundCnt <= roundCnt + 1'b1;
      end
    end
  end

  assign ctrl.capture = accept;
  assign ctrl.baseIdx = offsetReg + IDX_W'(roundCnt);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && roundCnt == LAST) |=> (done && !busy));

  assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !done));

  assert_offset_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(offsetReg));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !roundStrobe) |=> $stable(roundCnt));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/msl_datapath.sv
module msl_datapath
  import masked_sbox_layer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [STATE_W-1:0] stateIn,
  output logic [STATE_W-1:0] stateOut
);

  localparam int PAIRS = LANES / 2;

  logic [ADDR_W-1:0] laneAddrIn [LANES];
  logic [ADDR_W-1:0] laneAddrQ  [LANES];
  logic [BYTE_W-1:0] laneData   [LANES];
  logic [IDX_W-1:0]  regIdx     [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int DST = laneDest(j);
    logic [BYTE_W-1:0] corr;

    assign laneAddrIn[j] = {ctrl.baseIdx + IDX_W'(j), stateIn[j*BYTE_W +: BYTE_W]};
    assign regIdx[j]     = laneAddrQ[j][ADDR_W-1:BYTE_W];
    // Swap this lane's output mask for the one its destination lane expects
    assign corr = maskAt(regIdx[j] + 4'd1) ^ maskAt(regIdx[DST] + 4'd1);
    assign stateOut[j*BYTE_W +: BYTE_W] = laneData[j] ^ corr;

    if (j + 1 < LANES) begin : g_spacing
      assert_lane_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
        regIdx[j+1] == regIdx[j] + 4'd1);
    end
  end

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    msl_table #(.BASE_LANE(2*i)) u_table (
      .clk     (clk),
      .rstN    (rstN),
      .en      (ctrl.capture),
      .addrInA (laneAddrIn[2*i]),
      .addrInB (laneAddrIn[2*i+1]),
      .addrQA  (laneAddrQ[2*i]),
      .addrQB  (laneAddrQ[2*i+1]),
      .dataA   (laneData[2*i]),
      .dataB   (laneData[2*i+1])
    );
  end

endmodule

// File: rtl/masked_sbox_layer.sv
module masked_sbox_layer
  import masked_sbox_layer_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [3:0]     offsetIn,
  input  logic           roundStrobe,
  input  logic [127:0]   stateIn,
  output logic [127:0]   stateOut,
  output logic           done
);

  ctrl_t ctrl;

  msl_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .offsetIn    (offsetIn),
    .roundStrobe (roundStrobe),
    .ctrl        (ctrl),
    .done        (done)
  );

  msl_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .stateIn  (stateIn),
    .stateOut (stateOut)
  );

endmodule

// File: tb/masked_sbox_layer_bench.sv
`timescale 1ns/1ps
module masked_sbox_layer_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   offsetIn = 4'd0;
  logic         roundStrobe = 1'b0;
  logic [127:0] stateIn = '0;
  logic [127:0] stateOut;
  logic         done;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  logic [7:0] expT [256];
  logic [7:0] logT [256];

  localparam logic [7:0] MASKS [16] = '{8'd245, 8'd226, 8'd222, 8'd201, 8'd187, 8'd172,
    8'd144, 8'd135, 8'd120, 8'd111, 8'd83, 8'd68, 8'd54, 8'd33, 8'd29, 8'd10};

  typedef struct packed {
    logic [3:0] off;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{'{4'd0, 8'h00}, '{4'd5, 8'h3A},
                                '{4'd15, 8'hC7}, '{4'd9, 8'hFF}};

  always #5 clk = ~clk;

  masked_sbox_layer u_masked_sbox_layer (
    .clk(clk), .rstN(rstN), .start(start), .offsetIn(offsetIn),
    .roundStrobe(roundStrobe), .stateIn(stateIn), .stateOut(stateOut), .done(done)
  );

  function automatic logic [7:0] benchSbox(input logic [7:0] x);
    logic [7:0] v;
    v = (x == 8'h00) ? 8'h00 : expT[(255 - int'(logT[x])) % 255];
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic int destLane(input int s);
    return 4 * (((s / 4) + 4 - (s % 4)) % 4) + (s % 4);
  endfunction

  function automatic logic [7:0] plainByte(input logic [7:0] seed, input int j, input int r);
    return seed ^ 8'(17 * j) ^ 8'(29 * r);
  endfunction

  function automatic logic [127:0] maskedIn(input logic [3:0] off, input logic [7:0] seed,
                                            input int r);
    logic [127:0] v;
    for (int j = 0; j < 16; j++)
      v[j*8 +: 8] = plainByte(seed, j, r) ^ MASKS[(int'(off) + j + r) % 16];
    return v;
  endfunction

  function automatic logic [127:0] expOut(input logic [3:0] off, input logic [7:0] seed,
                                          input int r);
    logic [127:0] v;
    for (int s = 0; s < 16; s++)
      v[s*8 +: 8] = benchSbox(plainByte(seed, s, r))
                    ^ MASKS[(int'(off) + destLane(s) + r + 1) % 16];
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [3:0] off);
    @(negedge clk);
    start = 1'b1; offsetIn = off;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called at a negedge; strobes, then samples at the following negedge
  task automatic doRound(input logic [3:0] off, input logic [7:0] seed, input int r,
                         input string req);
    roundStrobe = 1'b1;
    stateIn = maskedIn(off, seed, r);
    @(negedge clk);
    roundStrobe = 1'b0;
    check(stateOut === expOut(off, seed, r), req, stateOut, expOut(off, seed, r));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic [127:0] rstExp;
    begin
      logic [7:0] a;
      a = 8'h01;
      for (int i = 0; i < 255; i++) begin
        expT[i] = a;
        logT[a] = 8'(i);
        a = (a[7] ? ((a << 1) ^ 8'h1B) : (a << 1)) ^ a;
      end
      expT[255] = 8'h01;
      logT[0] = 8'h00;
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 16; s++)
      rstExp[s*8 +: 8] = benchSbox(MASKS[s]) ^ MASKS[(destLane(s) + 1) % 16];
    check(done === 1'b0, "R8 done after reset", {127'd0, done}, 128'd0);
    check(stateOut === rstExp, "R8 output after reset", stateOut, rstExp);

    // Bench self-consistency against known S-box values (R1)
    check(benchSbox(8'h00) == 8'h63 && benchSbox(8'h53) == 8'hED,
          "R1 reference S-box", {120'd0, benchSbox(8'h53)}, {120'd0, 8'hED});

    // Vector table: full encryptions, back-to-back strobes (R2 R3 R4 R9 R5)
    for (int v = 0; v < 4; v++) begin
      doStart(VECS[v].off);
      for (int r = 0; r < 10; r++) begin
        doRound(VECS[v].off, VECS[v].seed, r,
                (VECS[v].off == 4'd15) ? "R9 R3 wrapped round" : "R3 R2 R4 round");
        if (r == 0)
          check(done === 1'b0, "R5 done low mid-run", {127'd0, done}, 128'd0);
      end
      check(done === 1'b1, "R5 done after last round", {127'd0, done}, 128'd1);
    end

    // Directed: literal value, pause, ignored start
    doStart(4'd0);
    doRound(4'd0, 8'h53, 0, "R3 round 0 directed");
    check(stateOut[7:0] === 8'h0F, "R1 literal lane0", {120'd0, stateOut[7:0]}, {120'd0, 8'h0F});
    for (int r = 1; r < 4; r++) doRound(4'd0, 8'h53, r, "R3 directed round");
    held = stateOut;
    stateIn = ~stateIn;
    start = 1'b1; offsetIn = 4'd11;
    @(negedge clk);
    start = 1'b0;
    check(stateOut === held, "R10 hold with start pulse", stateOut, held);
    stateIn = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    repeat (2) @(negedge clk);
    check(stateOut === held, "R10 hold without strobe", stateOut, held);
    for (int r = 4; r < 10; r++) doRound(4'd0, 8'h53, r, "R6 offset kept after busy start");
    check(done === 1'b1, "R6 R5 done with original count", {127'd0, done}, 128'd1);

    // R7: strobe while idle
    held = stateOut;
    roundStrobe = 1'b1;
    stateIn = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
    @(negedge clk);
    roundStrobe = 1'b0;
    @(negedge clk);
    check(stateOut === held, "R7 idle strobe output", stateOut, held);
    check(done === 1'b1, "R7 idle strobe done", {127'd0, done}, 128'd1);

    // R5: start clears done
    doStart(4'd7);
    check(done === 1'b0, "R5 start clears done", {127'd0, done}, 128'd0);
    doRound(4'd7, 8'h81, 0, "R2 new offset round 0");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule